// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Register Interface

This block sits between the host's parallel ATA bus and the internal logic of a storage device. It decodes programmed-I/O cycles, which are chip-select, register address, read/write strobe and a 16-bit data bus, into reads and writes of the device's task-file registers. Accepted host writes reach internal logic as a one-cycle pulse in the core clock domain, carrying the register address and data. Internal logic loads the status and error registers and supplies the data-port read word through a small local port. It raises interrupt requests through a single set input.

The block drives the interrupt line to the host. Depending on the host's device-select bit, it takes part in the bus or stays off it, so that two devices can share one cable. A strap input chooses whether the block answers as device 0 or device 1. That choice is taken once, when reset is released. The PIO ready output is held asserted at all times, so host cycles are never stretched.

Top module: `ata_taskfile_if`

## Requirements
- R1: With the primary select `cs_pri_n` low and `cs_alt_n` high, the address selects the register. Address 0 is the 16-bit data port. On read, address 1 returns the error register, and on write it is the features register. Addresses 2 to 5 are sector count and three LBA bytes. Address 6 is the device register. On read, address 7 returns status, and on write it is the command register. Registers at addresses 2 to 6 read back the last value written, in bits 7:0, with bits 15:8 zero.
- R2: With `cs_alt_n` low and `cs_pri_n` high, only address 6 responds. A read there returns the status register without side effects. A write there loads the device control register. Every other address in this group is not driven on read and is ignored on write, so no write pulse is produced.
- R3: `word_n` is low exactly while the primary group addresses the data port (address 0) and the device is selected. Otherwise it is high.
- R4: `iordy` is constantly high.
- R5: `strap_sel` is sampled in the first core clock cycle after reset release. A low level gives device 0 and a high level gives device 1. Later changes have no effect until the next reset.
- R6: `host_rst_n` low asynchronously clears every task-file, device control, status and error register, and clears the pending interrupt, to zero.
- R7: An accepted write produces `wr_pulse` high for exactly one cycle, together with `wr_addr`, `wr_data` and `wr_alt` (1 for the alternate group). The pulse is high in the cycle after the third core clock edge following the rising edge of `wr_n`.
- R8: `irq_set` sets a pending interrupt. `intrq` equals pending AND NOT nIEN AND selected.
- R9: A selected primary read of address 7 (status) clears the pending interrupt. Reading status through the alternate group leaves it pending.
- R10: Device control bit 1 (nIEN) masks `intrq`. A write with bit 2 (SRST) set gives a one-cycle `srst_pulse` that coincides with the `wr_pulse` of that write.
- R11: The device is selected when bit 4 (DEV) of the device register equals the strapped identity. While it is not selected, the data bus is released and writes are ignored. Writes to the device register and to device control are the exceptions and are still accepted.
- R12: `st_we` loads `st_val` into status, and `err_we` loads `err_val` into error. A primary read of address 0 returns `dp_rdata`. The end of that read gives a one-cycle `dp_rd_pulse`, due at the same cycle as the write pulse in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| host_rst_n | input | 1 | Host hardware reset, active low |
| cs_pri_n | input | 1 | Primary register group select, active low |
| cs_alt_n | input | 1 | Alternate/control group select, active low |
| addr | input | 3 | Register address |
| dat_in | input | 16 | Host data bus, write direction |
| dat_out | output | 16 | Host data bus, read direction |
| dat_oe | output | 1 | Data bus output enable |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| iordy | output | 1 | PIO ready, always high |
| word_n | output | 1 | 16-bit transfer indication, active low |
| intrq | output | 1 | Interrupt request to host |
| strap_sel | input | 1 | Device identity strap (0: device 0, 1: device 1) |
| wr_pulse | output | 1 | One-cycle pulse for an accepted host write |
| wr_addr | output | 3 | Address of the accepted write |
| wr_data | output | 16 | Data of the accepted write |
| wr_alt | output | 1 | Accepted write came from the alternate group |
| srst_pulse | output | 1 | Software reset request pulse |
| dp_rd_pulse | output | 1 | Data-port read completed |
| feat | output | 8 | Features register |
| count | output | 8 | Sector count register |
| lba | output | 24 | LBA bytes, high:mid:low |
| devsel | output | 8 | Device register |
| st_we | input | 1 | Load status register |
| st_val | input | 8 | Status value |
| err_we | input | 1 | Load error register |
| err_val | input | 8 | Error value |
| dp_rdata | input | 16 | Word returned on data-port reads |
| irq_set | input | 1 | Set pending interrupt |

## Verification
Read data, `dat_oe` and `word_n` are combinational from the selects, the address and `rd_n`. The bench samples them one falling edge after the read strobe goes low. Strobe-end effects pass through a two-flop synchroniser and an edge register, so `wr_pulse`, `srst_pulse` and `dp_rd_pulse` are high only in the cycle after the third rising edge. The bench samples them at the third falling edge after it drives the strobe high, and at the second and fourth falling edges to show they are absent. Register, interrupt and status effects are read back through the host bus five cycles after the strobe ends, or one falling edge after a local-port or `irq_set` pulse.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int unsigned TF_AW    = 3;
  localparam int unsigned TF_RW    = 8;
  localparam int unsigned TF_NREG  = 1 << TF_AW;
  localparam int unsigned DEV_BIT  = 4;
  localparam int unsigned NIEN_BIT = 1;
  localparam int unsigned SRST_BIT = 2;

  typedef enum logic [TF_AW-1:0] {
    TF_DATA    = 3'd0,
    TF_ERRFEAT = 3'd1,
    TF_COUNT   = 3'd2,
    TF_LBA0    = 3'd3,
    TF_LBA1    = 3'd4,
    TF_LBA2    = 3'd5,
    TF_DEVICE  = 3'd6,
    TF_STATCMD = 3'd7
  } tf_addr_e;
endpackage

// File: rtl/ata_tf_rst_sync.sv
module ata_tf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/ata_tf_edge_sync.sv
module ata_tf_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], strobe_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ev,
  input  logic             rd_ev,
  input  logic             pri_hit,
  input  logic             alt_hit,
  input  logic [TF_AW-1:0] addr,
  input  logic [DW-1:0]    dat_in,
  input  logic             sel,
  input  logic             st_we,
  input  logic [TF_RW-1:0] st_val,
  input  logic             err_we,
  input  logic [TF_RW-1:0] err_val,
  input  logic             irq_set,
  output logic             acc_pri,
  output logic             acc_alt,
  output logic [TF_RW-1:0] tf_q [TF_NREG],
  output logic [TF_RW-1:0] devctl_q,
  output logic [TF_RW-1:0] status_q,
  output logic [TF_RW-1:0] error_q,
  output logic             irq_pend_q
);
  logic            stat_rd;
  logic            irq_pend_d;

  assign acc_pri = wr_ev & pri_hit & (sel | (addr == TF_DEVICE));
  assign acc_alt = wr_ev & alt_hit & (addr == TF_DEVICE);
  assign stat_rd = rd_ev & pri_hit & sel & (addr == TF_STATCMD);

  // slot 0 is the data port, which has no storage
  assign tf_q[0] = '0;

  for (genvar i = 1; i < TF_NREG; i++) begin : g_tf
    logic we;
    assign we = acc_pri & (addr == TF_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tf_q[i] <= '0;
      else if (we) tf_q[i] <= dat_in[TF_RW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       devctl_q <= '0;
    else if (acc_alt) devctl_q <= dat_in[TF_RW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= '0;
    else if (st_we) status_q <= st_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      error_q <= '0;
    else if (err_we) error_q <= err_val;
  end

  always_comb begin
    irq_pend_d = irq_pend_q;
    if (stat_rd) irq_pend_d = 1'b0;
    if (irq_set) irq_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pend_q <= 1'b0;
    else        irq_pend_q <= irq_pend_d;
  end
endmodule

// File: rtl/ata_taskfile_if.sv
module ata_taskfile_if
  import ata_tf_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             host_rst_n,
  input  logic             cs_pri_n,
  input  logic             cs_alt_n,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    dat_in,
  output logic [DW-1:0]    dat_out,
  output logic             dat_oe,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic             iordy,
  output logic             word_n,
  output logic             intrq,
  input  logic             strap_sel,
  output logic             wr_pulse,
  output logic [2:0]       wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             wr_alt,
  output logic             srst_pulse,
  output logic             dp_rd_pulse,
  output logic [7:0]       feat,
  output logic [7:0]       count,
  output logic [23:0]      lba,
  output logic [7:0]       devsel,
  input  logic             st_we,
  input  logic [7:0]       st_val,
  input  logic             err_we,
  input  logic [7:0]       err_val,
  input  logic [DW-1:0]    dp_rdata,
  input  logic             irq_set
);
  localparam int unsigned PADW = DW - TF_RW;

  logic             rst_n;
  logic             wr_ev;
  logic             rd_ev;
  logic             pri_hit;
  logic             alt_hit;
  logic             sel;
  logic             acc_pri;
  logic             acc_alt;
  logic [TF_RW-1:0] tf_q [TF_NREG];
  logic [TF_RW-1:0] devctl_q;
  logic [TF_RW-1:0] status_q;
  logic [TF_RW-1:0] error_q;
  logic             irq_pend_q;

  logic             strap_done_q, is_slave_q;
  logic             wr_pulse_q, wr_pulse_d;
  logic [TF_AW-1:0] wr_addr_q;
  logic [DW-1:0]    wr_data_q;
  logic             wr_alt_q;
  logic             srst_q, srst_d;
  logic             dprd_q, dprd_d;
  logic [TF_RW-1:0] rd_byte;

  ata_tf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(host_rst_n), .rst_n(rst_n)
  );

  ata_tf_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .rise(wr_ev)
  );

  ata_tf_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .rise(rd_ev)
  );

  assign pri_hit = ~cs_pri_n & cs_alt_n;
  assign alt_hit = ~cs_alt_n & cs_pri_n;

  // identity strap: taken once after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done_q <= 1'b0;
      is_slave_q   <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      is_slave_q   <= strap_sel;
    end
  end

  assign sel = (tf_q[TF_DEVICE][DEV_BIT] == is_slave_q);

  ata_tf_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_ev),
    .pri_hit(pri_hit), .alt_hit(alt_hit), .addr(addr), .dat_in(dat_in),
    .sel(sel), .st_we(st_we), .st_val(st_val), .err_we(err_we),
    .err_val(err_val), .irq_set(irq_set), .acc_pri(acc_pri),
    .acc_alt(acc_alt), .tf_q(tf_q), .devctl_q(devctl_q),
    .status_q(status_q), .error_q(error_q), .irq_pend_q(irq_pend_q)
  );

  // internal-side pulses: next state
  always_comb begin
    wr_pulse_d = acc_pri | acc_alt;
    srst_d     = acc_alt & dat_in[SRST_BIT];
    dprd_d     = rd_ev & pri_hit & sel & (addr == TF_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse_q <= 1'b0;
      srst_q     <= 1'b0;
      dprd_q     <= 1'b0;
    end else begin
      wr_pulse_q <= wr_pulse_d;
      srst_q     <= srst_d;
      dprd_q     <= dprd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_alt_q  <= 1'b0;
    end else if (wr_pulse_d) begin
      wr_addr_q <= addr;
      wr_data_q <= dat_in;
      wr_alt_q  <= acc_alt;
    end
  end

  // host read path
  always_comb begin
    unique case (tf_addr_e'(addr))
      TF_ERRFEAT: rd_byte = error_q;
      TF_STATCMD: rd_byte = status_q;
      default:    rd_byte = tf_q[addr];
    endcase
  end

  always_comb begin
    dat_oe  = 1'b0;
    dat_out = '0;
    if (!rd_n && sel) begin
      if (pri_hit) begin
        dat_oe  = 1'b1;
        dat_out = (addr == TF_DATA) ? dp_rdata : {{PADW{1'b0}}, rd_byte};
      end else if (alt_hit && addr == TF_DEVICE) begin
        dat_oe  = 1'b1;
        dat_out = {{PADW{1'b0}}, status_q};
      end
    end
  end

  assign word_n      = ~(pri_hit & sel & (addr == TF_DATA));
  assign iordy       = 1'b1;
  assign intrq       = irq_pend_q & ~devctl_q[NIEN_BIT] & sel;

  assign wr_pulse    = wr_pulse_q;
  assign wr_addr     = wr_addr_q;
  assign wr_data     = wr_data_q;
  assign wr_alt      = wr_alt_q;
  assign srst_pulse  = srst_q;
  assign dp_rd_pulse = dprd_q;
  assign feat        = tf_q[TF_ERRFEAT];
  assign count       = tf_q[TF_COUNT];
  assign lba         = {tf_q[TF_LBA2], tf_q[TF_LBA1], tf_q[TF_LBA0]};
  assign devsel      = tf_q[TF_DEVICE];
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          host_rst_n,
  input logic          cs_pri_n,
  input logic          cs_alt_n,
  input logic [2:0]    addr,
  input logic          rd_n,
  input logic          dat_oe,
  input logic          word_n,
  input logic          intrq,
  input logic          wr_pulse,
  input logic          wr_alt,
  input logic [DW-1:0] wr_data,
  input logic          srst_pulse,
  input logic          dp_rd_pulse
);
  assert_word_decode_R3: assert property (@(posedge clk) disable iff (!host_rst_n)
    !word_n |-> (!cs_pri_n && cs_alt_n && addr == 3'd0));

  assert_bus_only_on_read_R11: assert property (@(posedge clk) disable iff (!host_rst_n)
    dat_oe |-> (!rd_n && (cs_pri_n != cs_alt_n)));

  assert_wr_pulse_single_R7: assert property (@(posedge clk) disable iff (!host_rst_n)
    wr_pulse |=> !wr_pulse);

  assert_nien_masks_R10: assert property (@(posedge clk) disable iff (!host_rst_n)
    (wr_pulse && wr_alt && wr_data[1]) |-> !intrq);

  assert_srst_with_write_R10: assert property (@(posedge clk) disable iff (!host_rst_n)
    srst_pulse |-> (wr_pulse && wr_alt && wr_data[2]));

  assert_dprd_single_R12: assert property (@(posedge clk) disable iff (!host_rst_n)
    dp_rd_pulse |=> !dp_rd_pulse);
endmodule

bind ata_taskfile_if ata_tf_checker #(.DW(DW)) u_chk (
  .clk(clk), .host_rst_n(host_rst_n), .cs_pri_n(cs_pri_n), .cs_alt_n(cs_alt_n),
  .addr(addr), .rd_n(rd_n), .dat_oe(dat_oe), .word_n(word_n), .intrq(intrq),
  .wr_pulse(wr_pulse), .wr_alt(wr_alt), .wr_data(wr_data),
  .srst_pulse(srst_pulse), .dp_rd_pulse(dp_rd_pulse)
);

// File: tb/tb_ata_taskfile_if.sv
module tb_ata_taskfile_if;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        host_rst_n;
  logic        cs_pri_n, cs_alt_n;
  logic [2:0]  addr;
  logic [15:0] dat_in, dat_out;
  logic        dat_oe, rd_n, wr_n, iordy, word_n, intrq, strap_sel;
  logic        wr_pulse, wr_alt, srst_pulse, dp_rd_pulse;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  feat, count, devsel;
  logic [23:0] lba;
  logic        st_we, err_we, irq_set;
  logic [7:0]  st_val, err_val;
  logic [15:0] dp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // captured by the access tasks
  logic        p2, p3, p4, s3, dprd3, alt3, r_oe, r_word;
  logic [2:0]  a3;
  logic [15:0] d3, r_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile_if dut (
    .clk(clk), .host_rst_n(host_rst_n), .cs_pri_n(cs_pri_n), .cs_alt_n(cs_alt_n),
    .addr(addr), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .rd_n(rd_n), .wr_n(wr_n), .iordy(iordy), .word_n(word_n), .intrq(intrq),
    .strap_sel(strap_sel), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_alt(wr_alt), .srst_pulse(srst_pulse),
    .dp_rd_pulse(dp_rd_pulse), .feat(feat), .count(count), .lba(lba),
    .devsel(devsel), .st_we(st_we), .st_val(st_val), .err_we(err_we),
    .err_val(err_val), .dp_rdata(dp_rdata), .irq_set(irq_set)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    strap_sel  = strap;
    host_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    host_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_wr(input logic alt, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_pri_n = alt;
    cs_alt_n = ~alt;
    addr     = a;
    dat_in   = d;
    wr_n     = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    p2 = wr_pulse;
    @(negedge clk);
    p3 = wr_pulse; a3 = wr_addr; d3 = wr_data; alt3 = wr_alt; s3 = srst_pulse;
    @(negedge clk);
    p4 = wr_pulse;
    @(negedge clk);
    cs_pri_n = 1'b1;
    cs_alt_n = 1'b1;
    dat_in   = '0;
  endtask

  task automatic host_rd(input logic alt, input logic [2:0] a);
    @(negedge clk);
    cs_pri_n = alt;
    cs_alt_n = ~alt;
    addr     = a;
    rd_n     = 1'b0;
    @(negedge clk);
    r_data = dat_out; r_oe = dat_oe; r_word = word_n;
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    dprd3 = dp_rd_pulse;
    repeat (2) @(negedge clk);
    cs_pri_n = 1'b1;
    cs_alt_n = 1'b1;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq_set = 1'b1;
    @(negedge clk);
    irq_set = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R4 iordy high", iordy, 1);
    check("R6 intrq low after reset", intrq, 0);
    host_rd(0, 3'd2);
    check("R6 count zero", r_data, 16'h0000);
    check("R1 count driven", r_oe, 1);
    check("R3 word_n high off data port", r_word, 1);
  endtask

  task automatic t_regs_readback();
    host_wr(0, 3'd2, 16'hAB12);
    host_wr(0, 3'd3, 16'h0034);
    host_wr(0, 3'd4, 16'h0056);
    host_wr(0, 3'd5, 16'h0078);
    host_wr(0, 3'd1, 16'h009A);
    host_rd(0, 3'd2); check("R1 count readback", r_data, 16'h0012);
    host_rd(0, 3'd4); check("R1 lba mid readback", r_data, 16'h0056);
    check("R1 lba output", lba, 24'h785634);
    check("R1 features output", feat, 8'h9A);
    host_rd(0, 3'd1); check("R1 error on read of addr 1", r_data, 16'h0000);
  endtask

  task automatic t_write_pulse();
    host_wr(0, 3'd7, 16'h00EC);
    check("R7 no pulse at edge 2", p2, 0);
    check("R7 pulse at edge 3", p3, 1);
    check("R7 pulse addr", a3, 3'd7);
    check("R7 pulse data", d3, 16'h00EC);
    check("R7 pulse primary", alt3, 0);
    check("R7 pulse gone at edge 4", p4, 0);
    host_wr(0, 3'd0, 16'h1234);
    check("R7 data port write pulse", {p3, a3, d3}, {1'b1, 3'd0, 16'h1234});
  endtask

  task automatic t_local_port();
    @(negedge clk);
    st_we = 1'b1; st_val = 8'h58; err_we = 1'b1; err_val = 8'h04;
    @(negedge clk);
    st_we = 1'b0; err_we = 1'b0;
    host_rd(0, 3'd7); check("R12 status read", r_data, 16'h0058);
    host_rd(0, 3'd1); check("R12 error read", r_data, 16'h0004);
    host_rd(1, 3'd6); check("R2 alt status read", r_data, 16'h0058);
    dp_rdata = 16'hBEEF;
    host_rd(0, 3'd0);
    check("R12 data port read", r_data, 16'hBEEF);
    check("R3 word_n low on data port", r_word, 0);
    check("R12 dp_rd_pulse", dprd3, 1);
  endtask

  task automatic t_irq();
    pulse_irq();
    check("R8 intrq after irq_set", intrq, 1);
    host_rd(1, 3'd6);
    check("R9 alt status keeps intrq", intrq, 1);
    host_rd(0, 3'd7);
    check("R9 status read clears intrq", intrq, 0);
  endtask

  task automatic t_devctl();
    pulse_irq();
    host_wr(1, 3'd6, 16'h0002);
    check("R10 nIEN masks intrq", intrq, 0);
    check("R10 no srst without bit 2", s3, 0);
    host_wr(1, 3'd6, 16'h0000);
    check("R10 unmask shows pending", intrq, 1);
    host_wr(1, 3'd6, 16'h0004);
    check("R10 srst pulse", {s3, p3, alt3}, 3'b111);
    host_rd(0, 3'd7);
  endtask

  task automatic t_alt_group();
    host_rd(1, 3'd5);
    check("R2 alt addr 5 not driven", r_oe, 0);
    host_wr(1, 3'd2, 16'h00FF);
    check("R2 alt addr 2 write no pulse", p3, 0);
    host_rd(0, 3'd2);
    check("R2 count unchanged", r_data, 16'h0012);
  endtask

  task automatic t_unselected();
    host_wr(0, 3'd6, 16'h0010);
    check("R11 device write accepted", devsel, 8'h10);
    host_rd(0, 3'd2);
    check("R11 bus released", r_oe, 0);
    host_rd(0, 3'd0);
    check("R11 word_n high unselected", r_word, 1);
    host_wr(0, 3'd2, 16'h0099);
    check("R11 write ignored no pulse", p3, 0);
    pulse_irq();
    check("R11 intrq low unselected", intrq, 0);
    host_wr(1, 3'd6, 16'h0004);
    check("R11 devctl accepted unselected", s3, 1);
    host_wr(0, 3'd6, 16'h0000);
    host_rd(0, 3'd2);
    check("R11 count kept after ignored write", r_data, 16'h0012);
    host_rd(0, 3'd7);
  endtask

  task automatic t_strap();
    @(negedge clk); strap_sel = 1'b1;
    host_rd(0, 3'd2);
    check("R5 late strap change ignored", r_oe, 1);
    do_reset(1'b1);
    host_rd(0, 3'd2);
    check("R5 slave strap unselected on DEV 0", r_oe, 0);
    @(negedge clk); strap_sel = 1'b0;
    host_wr(0, 3'd6, 16'h0010);
    host_rd(0, 3'd2);
    check("R5 slave selected on DEV 1", r_oe, 1);
    check("R6 count cleared by reset", r_data, 16'h0000);
    host_rd(0, 3'd7);
    check("R6 status cleared by reset", r_data, 16'h0000);
    check("R6 lba cleared by reset", lba, 24'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cs_pri_n = 1'b1; cs_alt_n = 1'b1; addr = '0; dat_in = '0;
    rd_n = 1'b1; wr_n = 1'b1; strap_sel = 1'b0;
    st_we = 1'b0; st_val = '0; err_we = 1'b0; err_val = '0;
    dp_rdata = '0; irq_set = 1'b0; host_rst_n = 1'b0;
    do_reset(1'b0);
    t_reset_state();
    t_regs_readback();
    t_write_pulse();
    t_local_port();
    t_irq();
    t_devctl();
    t_alt_group();
    t_unselected();
    t_strap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule